// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block sits between instruction fetch and the execution lanes of a multithreaded compute core. It keeps one instruction-buffer slot for each warp. Fetch may load at most one warp instruction per cycle into any slot that is free. Each buffered instruction names one destination register and two source registers. All three are tested against a pending-write scoreboard that is kept separately for each warp. A warp whose operands are all clear may be chosen. One winner per cycle is sent to the lanes. A selection input picks the policy: rotating priority, or oldest buffered instruction first.

Issuing an instruction frees its slot and marks its destination register pending for that warp. Writeback pulses from the arithmetic and memory pipelines clear those marks. A warp stalled on a long memory result therefore never holds up the other warps, and switching between warps costs no cycle. One warp instruction keeps the lanes busy for several cycles. A small dispatch state machine, with states LANES_IDLE and LANES_BUSY, holds off the next issue for that time. Its transitions are: launch (IDLE to BUSY on an issue), hold (BUSY to BUSY while the dispatch count runs), and release (BUSY to IDLE when the count reaches zero).

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `slot_busy` is all zero and `issue_valid` is 0. The scoreboard is clear and the rotation pointer is at warp 0.
- R2: A fill (`fill_valid`=1, `fill_warp`<NUM_WARPS) into a free slot makes that slot's `slot_busy` bit 1 on the next cycle and stores the instruction's destination and source fields. A fill into an occupied slot is ignored and leaves the stored fields unchanged.
- R3: `issue_valid` is a one-cycle pulse. It carries the warp index and the destination, source A and source B fields of the instruction held in that warp's slot. At most one instruction issues per cycle.
- R4: A warp may issue only when none of its three registers (source A, source B, destination) is pending in that warp's scoreboard.
- R5: An issue marks its destination register pending only for the issuing warp. Other warps that use the same register number are not affected.
- R6: A writeback pulse on any writeback port clears the pending mark of its (warp, register) pair, so a warp blocked by that register can issue on the following cycle. If a writeback and an issue hit the same pair in the same cycle, the mark stays set.
- R7: After an issue, no further issue happens for DISPATCH_CYCLES-1 cycles. Consecutive `issue_valid` pulses are at least DISPATCH_CYCLES cycles apart.
- R8: With `age_first`=0, the winner is the first eligible warp at or after the rotation pointer, wrapping past the last warp. The pointer then moves to winner+1, wrapping to 0.
- R9: With `age_first`=1, the winner is the eligible warp with the largest age. Age counts the cycles since the slot was filled and saturates at 2^AGE_W-1. Equal ages are resolved in the R8 rotation order.
- R10: A slot is freed on the edge where its instruction issues. A fill aimed at that slot during that same cycle is ignored. A fill on a later cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| age_first | input | 1 | 0: rotating priority, 1: oldest instruction first |
| fill_valid | input | 1 | A fetched instruction is offered this cycle |
| fill_warp | input | WID_W | Slot (warp) the offered instruction targets |
| fill_dst | input | REG_W | Destination register of the offered instruction |
| fill_src_a | input | REG_W | First source register |
| fill_src_b | input | REG_W | Second source register |
| wb_valid | input | NUM_WB | One writeback pulse per pipeline |
| wb_warp | input | NUM_WB*WID_W | Warp of each writeback, port p at bits p*WID_W upward |
| wb_reg | input | NUM_WB*REG_W | Register of each writeback, port p at bits p*REG_W upward |
| slot_busy | output | NUM_WARPS | Bit w set while warp w's slot holds an instruction |
| issue_valid | output | 1 | An instruction is dispatched this cycle |
| issue_warp | output | WID_W | Warp of the dispatched instruction |
| issue_dst | output | REG_W | Its destination register |
| issue_src_a | output | REG_W | Its first source register |
| issue_src_b | output | REG_W | Its second source register |

## Verification
The hardest case to produce from the ports is a writeback landing on the same edge as an issue to the same warp and register. A related case is a refill arriving exactly on the edge that frees its slot. Both need a particular phase against the dispatch window. The stimulus reaches them in two ways. Directed sequences hold a fill on one slot across its issue. A long random phase confines all register numbers to four values and drives dense writebacks on both ports under each policy. A behavioural reference model predicts every output on every cycle, so these collisions are checked whenever they occur.

// File: rtl/ws_pkg.sv
package ws_pkg;

    // Occupancy of the execution lanes by a dispatched warp instruction
    typedef enum logic [1:0] {
        LANES_IDLE = 2'd0,
        LANES_BUSY = 2'd1
    } lane_state_e;

endpackage

// File: rtl/ws_slot_buffer.sv
module ws_slot_buffer #(
    parameter int NUM_WARPS = 24,
    parameter int REG_W     = 4,
    parameter int AGE_W     = 6,
    parameter int WID_W     = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fill_valid,
    input  logic [WID_W-1:0]           fill_warp,
    input  logic [REG_W-1:0]           fill_dst,
    input  logic [REG_W-1:0]           fill_src_a,
    input  logic [REG_W-1:0]           fill_src_b,
    input  logic                       free_en,
    input  logic [WID_W-1:0]           free_warp,
    output logic [NUM_WARPS-1:0]       occ_o,
    output logic [NUM_WARPS*REG_W-1:0] dst_o,
    output logic [NUM_WARPS*REG_W-1:0] sa_o,
    output logic [NUM_WARPS*REG_W-1:0] sb_o,
    output logic [NUM_WARPS*AGE_W-1:0] age_o
);

    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
        logic             occ_q;
        logic [REG_W-1:0] dst_q, sa_q, sb_q;
        logic [AGE_W-1:0] age_q;
        logic             take, drop;

        // a fill lands only in an empty slot; the winner of issue leaves
        assign take = fill_valid && (fill_warp == WID_W'(w)) && !occ_q;
        assign drop = free_en && (free_warp == WID_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                occ_q <= 1'b0;
                dst_q <= '0;
                sa_q  <= '0;
                sb_q  <= '0;
                age_q <= '0;
            end else begin
                if (drop)
                    occ_q <= 1'b0;
                else if (take)
                    occ_q <= 1'b1;

                if (take) begin
                    dst_q <= fill_dst;
                    sa_q  <= fill_src_a;
                    sb_q  <= fill_src_b;
                    age_q <= '0;
                end else if (occ_q && age_q != AGE_MAX) begin
                    age_q <= age_q + 1'b1;
                end
            end
        end

        assign occ_o[w]                  = occ_q;
        assign dst_o[w*REG_W +: REG_W]   = dst_q;
        assign sa_o[w*REG_W +: REG_W]    = sa_q;
        assign sb_o[w*REG_W +: REG_W]    = sb_q;
        assign age_o[w*AGE_W +: AGE_W]   = age_q;
    end

endmodule

// File: rtl/ws_scoreboard.sv
module ws_scoreboard #(
    parameter int NUM_WARPS = 24,
    parameter int NUM_REGS  = 16,
    parameter int NUM_WB    = 2,
    parameter int REG_W     = 4,
    parameter int WID_W     = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_en,
    input  logic [WID_W-1:0]           set_warp,
    input  logic [REG_W-1:0]           set_reg,
    input  logic [NUM_WB-1:0]          wb_valid,
    input  logic [NUM_WB*WID_W-1:0]    wb_warp,
    input  logic [NUM_WB*REG_W-1:0]    wb_reg,
    input  logic [NUM_WARPS*REG_W-1:0] dst_i,
    input  logic [NUM_WARPS*REG_W-1:0] sa_i,
    input  logic [NUM_WARPS*REG_W-1:0] sb_i,
    output logic [NUM_WARPS-1:0]       clear_o
);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic [NUM_REGS-1:0] pend_q;
        logic [NUM_REGS-1:0] clr, set;
        logic [REG_W-1:0]    r_dst, r_sa, r_sb;

        always_comb begin
            clr = '0;
            for (int p = 0; p < NUM_WB; p++) begin
                if (wb_valid[p] && wb_warp[p*WID_W +: WID_W] == WID_W'(w))
                    clr[wb_reg[p*REG_W +: REG_W]] = 1'b1;
            end
            set = '0;
            if (set_en && set_warp == WID_W'(w))
                set[set_reg] = 1'b1;
        end

        // a new pending mark wins over a coincident writeback
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_q <= '0;
            else
                pend_q <= (pend_q & ~clr) | set;
        end

        assign r_dst = dst_i[w*REG_W +: REG_W];
        assign r_sa  = sa_i[w*REG_W +: REG_W];
        assign r_sb  = sb_i[w*REG_W +: REG_W];

        // destination is tested too, so a second write cannot overtake the first
        assign clear_o[w] = !pend_q[r_sa] && !pend_q[r_sb] && !pend_q[r_dst];
    end

endmodule

// File: rtl/ws_pick.sv
module ws_pick #(
    parameter int NUM_WARPS = 24,
    parameter int AGE_W     = 6,
    parameter int WID_W     = 5
) (
    input  logic [NUM_WARPS-1:0]       cand_i,
    input  logic [NUM_WARPS*AGE_W-1:0] age_i,
    input  logic [WID_W-1:0]           ptr_i,
    input  logic                       oldest_i,
    output logic                       found_o,
    output logic [WID_W-1:0]           winner_o
);

    logic [AGE_W-1:0] best;

    // walk the warps in rotation order from the pointer; in oldest mode a
    // strictly larger age displaces the current choice, so ties keep rotation order
    always_comb begin
        found_o  = 1'b0;
        winner_o = '0;
        best     = '0;
        for (int k = 0; k < NUM_WARPS; k++) begin
            int idx;
            idx = int'(ptr_i) + k;
            if (idx >= NUM_WARPS)
                idx = idx - NUM_WARPS;
            if (cand_i[idx]) begin
                if (!found_o || (oldest_i && age_i[idx*AGE_W +: AGE_W] > best)) begin
                    found_o  = 1'b1;
                    winner_o = WID_W'(idx);
                    best     = age_i[idx*AGE_W +: AGE_W];
                end
            end
        end
    end

endmodule

// File: rtl/ws_dispatch_fsm.sv
module ws_dispatch_fsm
    import ws_pkg::*;
#(
    parameter int DISPATCH_CYCLES = 4,
    localparam int CNT_W = (DISPATCH_CYCLES > 2) ? $clog2(DISPATCH_CYCLES - 1) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic lanes_free
);

    lane_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANES_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LANES_IDLE: begin
                // launch: lanes taken for the remaining dispatch beats
                if (launch && DISPATCH_CYCLES > 1) begin
                    state_d = LANES_BUSY;
                    cnt_d   = CNT_W'(DISPATCH_CYCLES - 2);
                end
            end
            LANES_BUSY: begin
                if (cnt_q == '0)
                    state_d = LANES_IDLE;      // release
                else
                    cnt_d = cnt_q - 1'b1;      // hold
            end
            default: begin
                state_d = LANES_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        lanes_free = (state_q == LANES_IDLE);
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import ws_pkg::*;
#(
    parameter int NUM_WARPS       = 24,
    parameter int NUM_REGS        = 16,
    parameter int NUM_WB          = 2,
    parameter int DISPATCH_CYCLES = 4,
    parameter int AGE_W           = 6,
    localparam int WID_W = $clog2(NUM_WARPS),
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    age_first,
    input  logic                    fill_valid,
    input  logic [WID_W-1:0]        fill_warp,
    input  logic [REG_W-1:0]        fill_dst,
    input  logic [REG_W-1:0]        fill_src_a,
    input  logic [REG_W-1:0]        fill_src_b,
    input  logic [NUM_WB-1:0]       wb_valid,
    input  logic [NUM_WB*WID_W-1:0] wb_warp,
    input  logic [NUM_WB*REG_W-1:0] wb_reg,
    output logic [NUM_WARPS-1:0]    slot_busy,
    output logic                    issue_valid,
    output logic [WID_W-1:0]        issue_warp,
    output logic [REG_W-1:0]        issue_dst,
    output logic [REG_W-1:0]        issue_src_a,
    output logic [REG_W-1:0]        issue_src_b
);

    logic [NUM_WARPS-1:0]       occ, hz_clear, cand;
    logic [NUM_WARPS*REG_W-1:0] dst_f, sa_f, sb_f;
    logic [NUM_WARPS*AGE_W-1:0] age_f;
    logic                       found, lanes_free, grant;
    logic [WID_W-1:0]           winner, ptr_q;
    logic [REG_W-1:0]           win_dst, win_sa, win_sb;

    ws_slot_buffer #(
        .NUM_WARPS(NUM_WARPS), .REG_W(REG_W), .AGE_W(AGE_W), .WID_W(WID_W)
    ) slots_i (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_warp(fill_warp),
        .fill_dst(fill_dst), .fill_src_a(fill_src_a), .fill_src_b(fill_src_b),
        .free_en(grant), .free_warp(winner),
        .occ_o(occ), .dst_o(dst_f), .sa_o(sa_f), .sb_o(sb_f), .age_o(age_f)
    );

    ws_scoreboard #(
        .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB),
        .REG_W(REG_W), .WID_W(WID_W)
    ) sb_i (
        .clk(clk), .rst_n(rst_n),
        .set_en(grant), .set_warp(winner), .set_reg(win_dst),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .dst_i(dst_f), .sa_i(sa_f), .sb_i(sb_f),
        .clear_o(hz_clear)
    );

    assign cand = occ & hz_clear;

    ws_pick #(
        .NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W), .WID_W(WID_W)
    ) pick_i (
        .cand_i(cand), .age_i(age_f), .ptr_i(ptr_q), .oldest_i(age_first),
        .found_o(found), .winner_o(winner)
    );

    ws_dispatch_fsm #(
        .DISPATCH_CYCLES(DISPATCH_CYCLES)
    ) lanes_i (
        .clk(clk), .rst_n(rst_n), .launch(grant), .lanes_free(lanes_free)
    );

    assign grant   = found && lanes_free;
    assign win_dst = dst_f[int'(winner)*REG_W +: REG_W];
    assign win_sa  = sa_f[int'(winner)*REG_W +: REG_W];
    assign win_sb  = sb_f[int'(winner)*REG_W +: REG_W];

    // rotation pointer and registered dispatch record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            issue_valid <= 1'b0;
            issue_warp  <= '0;
            issue_dst   <= '0;
            issue_src_a <= '0;
            issue_src_b <= '0;
        end else begin
            issue_valid <= grant;
            if (grant) begin
                ptr_q       <= (int'(winner) == NUM_WARPS - 1) ? '0 : winner + 1'b1;
                issue_warp  <= winner;
                issue_dst   <= win_dst;
                issue_src_a <= win_sa;
                issue_src_b <= win_sb;
            end
        end
    end

    assign slot_busy = occ;

endmodule

// File: rtl/ws_checker.sv
module ws_checker #(
    parameter int NUM_WARPS       = 24,
    parameter int DISPATCH_CYCLES = 4,
    parameter int WID_W           = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fill_valid,
    input logic [WID_W-1:0]     fill_warp,
    input logic [NUM_WARPS-1:0] slot_busy,
    input logic                 issue_valid,
    input logic [WID_W-1:0]     issue_warp
);

    localparam int SW = $clog2(DISPATCH_CYCLES + 1) + 1;
    localparam logic [SW-1:0] SINCE_MAX = SW'(DISPATCH_CYCLES);

    logic [SW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_q <= SINCE_MAX;
        else if (issue_valid)
            since_q <= '0;
        else if (since_q != SINCE_MAX)
            since_q <= since_q + 1'b1;
    end

    // R7: issue pulses keep the dispatch spacing
    a_r7_dispatch_gap: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (int'(since_q) >= DISPATCH_CYCLES - 1));

    // R10: the issuing slot is already empty while the pulse is out
    a_r10_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !slot_busy[issue_warp]);

    // R3: an issued warp held an instruction on the cycle before
    a_r3_from_held_slot: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> |($past(slot_busy) & (NUM_WARPS'(1) << issue_warp)));

    // R2: a fill into an empty slot occupies it
    a_r2_fill_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && int'(fill_warp) < NUM_WARPS && !slot_busy[fill_warp])
        |=> slot_busy[$past(fill_warp)]);

    // R10: a slot empties only through an issue
    a_r10_free_only_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(slot_busy) & ~slot_busy)) |-> issue_valid);

endmodule

bind warp_issue_sched ws_checker #(
    .NUM_WARPS(NUM_WARPS), .DISPATCH_CYCLES(DISPATCH_CYCLES), .WID_W(WID_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_warp(fill_warp),
    .slot_busy(slot_busy), .issue_valid(issue_valid), .issue_warp(issue_warp)
);

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;

    localparam int NW    = 24;
    localparam int NR    = 16;
    localparam int NWB   = 2;
    localparam int DISP  = 4;
    localparam int AGEW  = 6;
    localparam int WW    = 5;
    localparam int RW    = 4;
    localparam int AGMAX = (1 << AGEW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              age_first = 1'b0;
    logic              fill_valid = 1'b0;
    logic [WW-1:0]     fill_warp = '0;
    logic [RW-1:0]     fill_dst = '0, fill_src_a = '0, fill_src_b = '0;
    logic [NWB-1:0]    wb_valid = '0;
    logic [NWB*WW-1:0] wb_warp = '0;
    logic [NWB*RW-1:0] wb_reg = '0;
    logic [NW-1:0]     slot_busy;
    logic              issue_valid;
    logic [WW-1:0]     issue_warp;
    logic [RW-1:0]     issue_dst, issue_src_a, issue_src_b;

    always #2.5 clk = ~clk;

    warp_issue_sched dut_i (
        .clk(clk), .rst_n(rst_n), .age_first(age_first),
        .fill_valid(fill_valid), .fill_warp(fill_warp), .fill_dst(fill_dst),
        .fill_src_a(fill_src_a), .fill_src_b(fill_src_b),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .slot_busy(slot_busy), .issue_valid(issue_valid), .issue_warp(issue_warp),
        .issue_dst(issue_dst), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b)
    );

    int n_chk = 0, n_bad = 0;

    function automatic void chk(input string tag, input string what,
                                input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endfunction

    // ---------------- behavioural reference model ----------------
    bit m_occ[NW];
    int m_dst[NW], m_sa[NW], m_sb[NW], m_age[NW];
    bit m_pend[NW][NR];
    int m_busy, m_ptr;
    bit e_v;
    int e_w, e_d, e_a, e_b;

    always @(posedge clk or negedge rst_n) begin : mdl
        int win, best, idx, fw;
        bit acc;
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                m_occ[w] = 0; m_age[w] = 0;
                for (int r = 0; r < NR; r++) m_pend[w][r] = 0;
            end
            m_busy = 0; m_ptr = 0; e_v = 0;
        end else begin
            win = -1; best = 0;
            if (m_busy == 0) begin
                for (int k = 0; k < NW; k++) begin
                    idx = (m_ptr + k) % NW;
                    if (m_occ[idx] && !m_pend[idx][m_sa[idx]] && !m_pend[idx][m_sb[idx]]
                        && !m_pend[idx][m_dst[idx]]) begin
                        if (win < 0 || (age_first && m_age[idx] > best)) begin
                            win = idx; best = m_age[idx];
                        end
                    end
                end
            end
            for (int p = 0; p < NWB; p++)
                if (wb_valid[p]) m_pend[int'(wb_warp[p*WW +: WW])][int'(wb_reg[p*RW +: RW])] = 0;
            fw  = int'(fill_warp);
            acc = fill_valid && fw < NW && !m_occ[fw];
            for (int w = 0; w < NW; w++)
                if (m_occ[w] && m_age[w] < AGMAX) m_age[w]++;
            e_v = (win >= 0);
            if (win >= 0) begin
                m_pend[win][m_dst[win]] = 1;
                e_w = win; e_d = m_dst[win]; e_a = m_sa[win]; e_b = m_sb[win];
                m_ptr = (win + 1) % NW;
                m_busy = DISP - 1;
                m_occ[win] = 0;
            end else if (m_busy > 0) begin
                m_busy--;
            end
            if (acc) begin
                m_occ[fw] = 1; m_age[fw] = 0;
                m_dst[fw] = int'(fill_dst); m_sa[fw] = int'(fill_src_a); m_sb[fw] = int'(fill_src_b);
            end
        end
    end

    // ---------------- per-cycle comparison and issue log ----------------
    int cyc = 0, last_iss = -1;
    int log_w[$], log_a[$], log_d[$];

    always @(negedge clk) begin : cmp
        logic [NW-1:0] eb;
        cyc++;
        if (rst_n) begin
            for (int w = 0; w < NW; w++) eb[w] = m_occ[w];
            chk("R3", "issue_valid", issue_valid, e_v);
            chk("R10", "slot_busy", slot_busy, eb);
            if (e_v && issue_valid) begin
                chk(age_first ? "R9" : "R8", "issue_warp", issue_warp, e_w);
                chk("R2", "issue_dst", issue_dst, e_d);
                chk("R2", "issue_src_a", issue_src_a, e_a);
                chk("R2", "issue_src_b", issue_src_b, e_b);
            end
            if (issue_valid) begin
                if (last_iss >= 0) chk("R7", "issue spacing ok", (cyc - last_iss) >= DISP, 1);
                last_iss = cyc;
                log_w.push_back(int'(issue_warp));
                log_a.push_back(int'(issue_src_a));
                log_d.push_back(int'(issue_dst));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic fill(input int w, input int d, input int a, input int b);
        fill_valid = 1'b1; fill_warp = WW'(w);
        fill_dst = RW'(d); fill_src_a = RW'(a); fill_src_b = RW'(b);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic wback(input int p, input int w, input int r);
        wb_valid[p] = 1'b1; wb_warp[p*WW +: WW] = WW'(w); wb_reg[p*RW +: RW] = RW'(r);
        @(negedge clk);
        wb_valid = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int count_of(input int w);
        int c = 0;
        foreach (log_w[i]) if (log_w[i] == w) c++;
        return c;
    endfunction

    function automatic void summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R3 watchdog: actual %0d expected %0d (cycles)", 200000, 0);
        summary();
        $finish;
    end

    initial begin : main
        // R1: reset state
        idle(3);
        chk("R1", "slot_busy in reset", slot_busy, 0);
        chk("R1", "issue_valid in reset", issue_valid, 0);
        rst_n = 1'b1;
        idle(1);
        chk("R1", "slot_busy after reset", slot_busy, 0);
        chk("R1", "issue_valid after reset", issue_valid, 0);

        // R8: rotation order over independent warps
        for (int w = 0; w < 6; w++) fill(w, 1, 2, 3);
        idle(30);
        for (int w = 0; w < 6; w++) chk("R8", "rotation order", log_w[w], w);

        // R4 / R5 / R6: per-warp dependency
        fill(7, 3, 0, 0);
        idle(8);
        log_w.delete(); log_a.delete(); log_d.delete();
        fill(7, 4, 3, 0);          // blocked on r3 of warp 7
        fill(8, 4, 3, 0);          // same register, other warp
        idle(20);
        chk("R4", "blocked warp issues", count_of(7), 0);
        chk("R5", "other warp unaffected", count_of(8), 1);
        chk("R4", "blocked slot held", slot_busy[7], 1);
        wback(1, 7, 3);
        idle(8);
        chk("R6", "warp released by writeback", count_of(7), 1);

        // R9: oldest first
        age_first = 1'b1;
        log_w.delete();
        fill(20, 8, 9, 10); fill(15, 8, 9, 10); fill(3, 8, 9, 10); fill(9, 8, 9, 10);
        idle(20);
        chk("R9", "oldest #0", log_w[0], 20);
        chk("R9", "oldest #1", log_w[1], 15);
        chk("R9", "oldest #2", log_w[2], 3);
        chk("R9", "oldest #3", log_w[3], 9);

        // R8: same arrival pattern under rotation
        age_first = 1'b0;
        log_w.delete();
        fill(20, 11, 12, 13); fill(15, 11, 12, 13); fill(3, 11, 12, 13); fill(9, 11, 12, 13);
        idle(20);
        chk("R8", "rotation #0", log_w[0], 20);
        chk("R8", "rotation #1", log_w[1], 3);
        chk("R8", "rotation #2", log_w[2], 9);
        chk("R8", "rotation #3", log_w[3], 15);

        // R2: fill into occupied slot is ignored
        fill(12, 5, 0, 0);
        idle(6);
        fill(12, 6, 5, 0);         // blocked on r5
        idle(2);
        fill(12, 7, 1, 1);         // must be dropped
        idle(6);
        chk("R2", "slot kept", slot_busy[12], 1);
        log_w.delete(); log_a.delete(); log_d.delete();
        wback(0, 12, 5);
        idle(8);
        chk("R6", "issue after port-0 writeback", count_of(12), 1);
        if (log_a.size() > 0) begin
            chk("R2", "stored src_a kept", log_a[0], 5);
            chk("R2", "stored dst kept", log_d[0], 6);
        end

        // R10: fill held across the issue edge; refill later blocks on WAW
        log_w.delete();
        fill_valid = 1'b1; fill_warp = WW'(14); fill_dst = 2; fill_src_a = 0; fill_src_b = 0;
        idle(12);
        fill_valid = 1'b0;
        idle(8);
        chk("R10", "single issue of held fill", count_of(14), 1);
        chk("R10", "refill accepted later", slot_busy[14], 1);

        // random phase, both policies, narrow register range
        for (int ph = 0; ph < 2; ph++) begin
            age_first = ph[0];
            for (int i = 0; i < 3000; i++) begin
                fill_valid = ($urandom_range(0, 1) == 1);
                fill_warp  = WW'($urandom_range(0, NW - 1));
                fill_dst   = RW'($urandom_range(0, 3));
                fill_src_a = RW'($urandom_range(0, 3));
                fill_src_b = RW'($urandom_range(0, 3));
                for (int p = 0; p < NWB; p++) begin
                    wb_valid[p] = ($urandom_range(0, 9) < 3);
                    wb_warp[p*WW +: WW] = WW'($urandom_range(0, NW - 1));
                    wb_reg[p*RW +: RW]  = RW'($urandom_range(0, 3));
                end
                @(negedge clk);
            end
            fill_valid = 1'b0; wb_valid = '0;
            idle(10);
        end

        summary();
        $finish;
    end

endmodule